// File: doc/BRIEF.md
# Gated Fast-Rotation Phase Generator

This block produces the phase word for a downstream cosine table, arranged so that a low-frequency output does not crawl slowly through the table. It has two accumulators. A wide, slowly tuned gate accumulator sets the repetition rate. A narrower, quickly tuned rotor accumulator sets how fast the table is swept. The phase word rests at zero (0°) nearly all of the time. Each time the gate accumulator carries out, the rotor is released and the phase makes one complete turn at the fast rate, then parks at zero again. In effect it is a divider placed ahead of the cosine lookup and the DAC.

Both tuning words can be changed in any cycle without a reset. A one-cycle trigger flag marks the cycle in which the swept phase first enters the upper half-turn, so downstream timing logic gets one clean event per rotation. The cosine table and the DAC are outside this block.

Top module: `gated_rotor_phase`

## Requirements
- R1: While `rst_n` is low at a rising edge, both accumulators and the rotor state clear. After that edge `phase_out` is 0 and `trig_out` is 0, and the gate accumulator restarts counting from 0.
- R2: At every edge the gate accumulator adds `slow_word` modulo 2^SLOW_W. If that addition carries out at edge k and the rotor is parked at edge k+1, a rotation starts at edge k+1. After edge k+1, `phase_out` equals bits [FAST_W-1 : FAST_W-OUT_W] of `fast_word`. With `slow_word` at 0, no rotation ever starts.
- R3: While the rotor is parked, `phase_out` is 0.
- R4: At each edge during a rotation, the rotor phase advances by `fast_word` modulo 2^FAST_W. `phase_out` is the top OUT_W bits of the rotor phase.
- R5: A rotation ends at the edge where the rotor addition carries out. At that edge the rotor phase is forced to 0 and the rotor parks, so each rotation covers exactly one turn. With the default widths, `fast_word` = 0x200 gives 7 consecutive cycles of non-zero `phase_out`.
- R6: A gate carry that arrives while the rotor is spinning, including at the edge where the rotation ends, is discarded. It is not queued and it does not restart the current rotation.
- R7: A change of `slow_word` during a rotation does not stop or alter that rotation. A change of `fast_word` takes effect as the step from the next edge on.
- R8: `trig_out` is high for exactly one cycle, in the cycle where the top bit of `phase_out` is 1 and was 0 in the previous cycle (the half-turn crossing). It never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| slow_word | input | SLOW_W | Gate tuning word; its carry rate sets the rotation repetition rate |
| fast_word | input | FAST_W | Rotor tuning word; the phase step per cycle during a rotation |
| phase_out | output | OUT_W | Phase word for the cosine table, 0 while parked |
| trig_out | output | 1 | One-cycle flag at the half-turn crossing of a rotation |

## Verification
Wrong internal state shows up at the ports very quickly. If the rotor state is stuck or wrong, `phase_out` either sits non-zero while the reference has parked or stays at 0 through a sweep, and the next cycle's comparison catches it. A gate carry that is lost or wrongly accepted moves the start of the next sweep by at least one gate period, which shows in the first cycle of that sweep. Rotations that run too long or too short are caught by the run-length checks within a single sweep. A misplaced trigger shows up in the same cycle as the half-turn crossing.

// File: rtl/grp_pkg.sv
// Package: shared types for the gated rotor phase generator.
// Assumes: nothing beyond IEEE 1800-2017.
package grp_pkg;

    // Rotor state: parked at zero phase, or spinning through one turn
    typedef enum logic {
        ST_PARK = 1'b0,
        ST_SPIN = 1'b1
    } rot_state_e;

endpackage

// File: rtl/grp_gate_acc.sv
// Module: grp_gate_acc
// Slow gate accumulator. It adds the step word at every edge, modulo
// 2^SLOW_W, and registers the carry out as a one-cycle gate pulse.
// Assumes: the step word may change in any cycle; a step of 0 never carries.
module grp_gate_acc #(
    parameter int SLOW_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOW_W-1:0] step,
    output logic              wrap
);

    logic [SLOW_W-1:0] acc_q;
    logic [SLOW_W:0]   sum;

    // Widened sum so the carry out is explicit
    assign sum = {1'b0, acc_q} + {1'b0, step};

    // Accumulate, and register the carry as the gate pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            wrap  <= 1'b0;
        end else begin
            acc_q <= sum[SLOW_W-1:0];
            wrap  <= sum[SLOW_W];
        end
    end

endmodule

// File: rtl/grp_rotor.sv
// Module: grp_rotor
// Fast rotor. When parked, its phase is held at 0. A start request seen
// while parked loads the step as the first phase of a rotation. While
// spinning, the phase advances by the step; a carry out ends the
// rotation and forces the phase back to 0.
// Assumes: start requests that arrive while spinning are meant to be dropped.
module grp_rotor
    import grp_pkg::*;
#(
    parameter int FAST_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [FAST_W-1:0] step,
    output logic [FAST_W-1:0] phase,
    output logic              spinning,
    output logic              next_msb
);

    rot_state_e        st_q, st_d;
    logic [FAST_W-1:0] ph_q, ph_d;
    logic [FAST_W:0]   sum;

    // Widened phase sum so the end-of-turn carry is explicit
    assign sum = {1'b0, ph_q} + {1'b0, step};

    // Next state and phase: one turn per accepted start
    always_comb begin
        st_d = st_q;
        ph_d = ph_q;
        case (st_q)
            ST_SPIN: begin
                if (sum[FAST_W]) begin
                    st_d = ST_PARK;
                    ph_d = '0;
                end else begin
                    ph_d = sum[FAST_W-1:0];
                end
            end
            default: begin
                ph_d = '0;
                if (start) begin
                    st_d = ST_SPIN;
                    ph_d = step;
                end
            end
        endcase
    end

    // State and phase registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_PARK;
            ph_q <= '0;
        end else begin
            st_q <= st_d;
            ph_q <= ph_d;
        end
    end

    assign phase    = ph_q;
    assign spinning = (st_q == ST_SPIN);
    assign next_msb = ph_d[FAST_W-1];

endmodule

// File: rtl/grp_half_detect.sv
// Module: grp_half_detect
// Half-turn detector. It registers a one-cycle flag for the edge where the
// phase top bit goes from 0 to 1, so the flag lines up with the phase
// register it describes.
// Assumes: cur_msb and next_msb are the current and next value of the same bit.
module grp_half_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic cur_msb,
    input  logic next_msb,
    output logic trig
);

    // Flag the rising edge of the phase top bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig <= 1'b0;
        end else begin
            trig <= next_msb & ~cur_msb;
        end
    end

endmodule

// File: rtl/gated_rotor_phase.sv
// Module: gated_rotor_phase (top)
// A slow gate accumulator releases a fast rotor for one full turn at each
// carry. The rotor phase, truncated to OUT_W bits, drives a cosine table,
// and a trigger marks the half-turn crossing.
// Assumes: OUT_W <= FAST_W; both tuning words may change in any cycle.
module gated_rotor_phase #(
    parameter int SLOW_W = 16,
    parameter int FAST_W = 12,
    parameter int OUT_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOW_W-1:0] slow_word,
    input  logic [FAST_W-1:0] fast_word,
    output logic [OUT_W-1:0]  phase_out,
    output logic              trig_out
);

    localparam int PH_LSB = FAST_W - OUT_W;

    logic              gate_wrap;
    logic              rot_spin;
    logic              rot_next_msb;
    logic [FAST_W-1:0] rot_phase;

    grp_gate_acc #(.SLOW_W(SLOW_W)) u_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (slow_word),
        .wrap  (gate_wrap)
    );

    grp_rotor #(.FAST_W(FAST_W)) u_rotor (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (gate_wrap),
        .step     (fast_word),
        .phase    (rot_phase),
        .spinning (rot_spin),
        .next_msb (rot_next_msb)
    );

    grp_half_detect u_half (
        .clk      (clk),
        .rst_n    (rst_n),
        .cur_msb  (rot_phase[FAST_W-1]),
        .next_msb (rot_next_msb),
        .trig     (trig_out)
    );

    // Output phase: the top OUT_W bits of the rotor phase
    assign phase_out = rot_phase[FAST_W-1:PH_LSB];

endmodule

// File: rtl/grp_chk.sv
// Module: grp_chk
// Assertion checker for gated_rotor_phase, attached with bind below.
// Assumes: connected to the top's ports and its rotor/gate internal nets.
module grp_chk #(
    parameter int FAST_W = 12,
    parameter int OUT_W  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [FAST_W-1:0] fast_word,
    input logic [OUT_W-1:0]  phase_out,
    input logic              trig_out,
    input logic              spinning,
    input logic [FAST_W-1:0] fast_phase,
    input logic              gate_wrap
);

    logic [FAST_W:0] chk_sum;
    assign chk_sum = {1'b0, fast_phase} + {1'b0, fast_word};

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (phase_out == '0) && !trig_out); // R1

    AST_GATE_START: assert property (@(posedge clk) disable iff (!rst_n)
        !spinning && gate_wrap |=> spinning); // R2

    AST_PARK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !spinning |-> (phase_out == '0)); // R3

    AST_SPIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        spinning && $past(spinning) |->
            fast_phase == FAST_W'($past(fast_phase) + $past(fast_word))); // R4

    AST_TURN_END: assert property (@(posedge clk) disable iff (!rst_n)
        spinning && chk_sum[FAST_W] |=> !spinning && (phase_out == '0)); // R5

    AST_WRAP_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        spinning && gate_wrap && !chk_sum[FAST_W] |=> spinning); // R6

    AST_TRIG_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        trig_out |-> phase_out[OUT_W-1] && !$past(phase_out[OUT_W-1])); // R8

    AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        trig_out |=> !trig_out); // R8

endmodule

bind gated_rotor_phase grp_chk #(
    .FAST_W (FAST_W),
    .OUT_W  (OUT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fast_word  (fast_word),
    .phase_out  (phase_out),
    .trig_out   (trig_out),
    .spinning   (rot_spin),
    .fast_phase (rot_phase),
    .gate_wrap  (gate_wrap)
);

// File: tb/gated_rotor_phase_tb.sv
// Bench: behavioural reference model compared on every clock, plus
// directed checks on start timing and rotation length.
module gated_rotor_phase_tb;

    localparam int SW = 16;
    localparam int FW = 12;
    localparam int OW = 10;
    localparam longint SMOD = 64'd1 << SW;
    localparam longint FMOD = 64'd1 << FW;
    localparam longint HALF = 64'd1 << (FW - 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [SW-1:0] slow_word = '0;
    logic [FW-1:0] fast_word = '0;
    logic [OW-1:0] phase_out;
    logic          trig_out;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    bit    cmp_en = 1'b0;
    bit    done   = 1'b0;
    string cur_req = "R1";

    // reference model state
    longint m_s = 0, m_f = 0;
    bit     m_spin = 0, m_wrap = 0, m_trig = 0;

    // run-length monitor of non-zero phase
    int run_len = 0;
    int last_run = 0;

    gated_rotor_phase #(.SLOW_W(SW), .FAST_W(FW), .OUT_W(OW)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_word (slow_word),
        .fast_word (fast_word),
        .phase_out (phase_out),
        .trig_out  (trig_out)
    );

    always #5 clk = ~clk;

    // reference model, advanced at each rising edge
    always @(posedge clk) begin
        longint nf, t;
        bit     ns;
        if (!rst_n) begin
            m_s = 0; m_f = 0; m_spin = 0; m_wrap = 0; m_trig = 0;
        end else begin
            nf = m_f;
            ns = m_spin;
            if (m_spin) begin
                t = m_f + longint'(fast_word);
                if (t >= FMOD) begin ns = 0; nf = 0; end
                else nf = t;
            end else if (m_wrap) begin
                ns = 1; nf = longint'(fast_word);
            end
            m_trig = (nf >= HALF) && (m_f < HALF);
            t = m_s + longint'(slow_word);
            m_wrap = (t >= SMOD);
            m_s = t % SMOD;
            m_f = nf;
            m_spin = ns;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // cycle-by-cycle comparison and run-length monitor, away from the edge
    always @(negedge clk) begin
        if (cmp_en) begin
            check(longint'(phase_out) == (m_f >> (FW - OW)), cur_req, "phase",
                  longint'(phase_out), m_f >> (FW - OW));
            check(trig_out == m_trig, cur_req == "R1" ? "R8" : cur_req, "trig",
                  longint'(trig_out), longint'(m_trig));
        end
        if (phase_out != '0) run_len++;
        else if (run_len > 0) begin last_run = run_len; run_len = 0; end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected <= 20000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // R1: reset clears outputs
        rst_n = 1'b0;
        slow_word = 16'h8000;
        fast_word = 12'h400;
        wait_cyc(3);
        check(phase_out == '0, "R1", "phase in reset", longint'(phase_out), 0);
        check(trig_out == 1'b0, "R1", "trig in reset", longint'(trig_out), 0);
        cmp_en = 1'b1;
        rst_n = 1'b1;

        // R2: carry at edge 2, rotation visible after edge 3
        cur_req = "R2";
        wait_cyc(1);
        check(phase_out == '0, "R2", "phase after edge 1", longint'(phase_out), 0);
        wait_cyc(1);
        check(phase_out == '0, "R2", "phase after edge 2", longint'(phase_out), 0);
        wait_cyc(1);
        check(phase_out == 10'h100, "R2", "first sweep phase", longint'(phase_out), 'h100);

        // R6: gate carries every 2 cycles, most arrive mid-rotation
        cur_req = "R6";
        fast_word = 12'h100;
        wait_cyc(80);

        // R4/R5: 8-step rotation, repeat every 16 cycles
        cur_req = "R4";
        slow_word = 16'h1000;
        fast_word = 12'h200;
        wait_cyc(70);
        cur_req = "R5";
        wait_cyc(30);
        check(last_run == 7, "R5", "sweep length", longint'(last_run), 7);

        // R8: step above half a turn, crossing on the first sweep sample
        cur_req = "R8";
        fast_word = 12'h900;
        wait_cyc(40);
        fast_word = 12'h300;
        wait_cyc(40);

        // R3: parked output stays zero with no gate carries
        cur_req = "R3";
        slow_word = 16'h0000;
        wait_cyc(60);
        check(phase_out == '0, "R3", "parked phase", longint'(phase_out), 0);

        // R7: slow word cleared mid-rotation, sweep still completes
        cur_req = "R7";
        fast_word = 12'h080;
        slow_word = 16'h4000;
        while (phase_out == '0) @(negedge clk);
        slow_word = 16'h0000;
        wait_cyc(5);
        check(phase_out != '0, "R7", "still sweeping", longint'(phase_out), 1);
        wait_cyc(50);
        check(last_run == 31, "R7", "sweep length after slow change",
              longint'(last_run), 31);

        // R2: zero slow word, no further rotations
        cur_req = "R2";
        wait_cyc(100);
        check(phase_out == '0, "R2", "no start with zero slow word",
              longint'(phase_out), 0);

        // R7: fast word change mid-rotation
        cur_req = "R7";
        slow_word = 16'h2000;
        fast_word = 12'h040;
        while (phase_out == '0) @(negedge clk);
        wait_cyc(10);
        fast_word = 12'h400;
        wait_cyc(60);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule